// File: doc/BRIEF.md
# Port Input/Output Instruction Bus Cycle Sequencer

This block is a small bus master for a processor bus that multiplexes the low address byte with the data. It runs only the two-byte port transfer instructions. On a start request it reads the opcode at the program counter. It then reads the byte after the opcode, which names the port. Last, it runs an I/O cycle. That cycle either writes the accumulator to the port or loads the accumulator from the port.

The bus is driven with T-state timing, one clock per T-state. The opcode fetch lasts four T-states. The port-number read and the I/O cycle last three T-states each. The address strobe is high only in the first T-state of each machine cycle. During the I/O cycle the port number appears on both the high address byte and the low address/data lines.

An opcode that is neither transfer instruction ends the sequence after the fetch and raises an error pulse. A completed instruction raises a done pulse and moves the program counter past both bytes. The surrounding system supplies program bytes and port data through the bus read input.

Top module: `io_insn_sequencer`

## Requirements
- R1: After reset the bus is idle: addr_strobe=0, rd_n=1, wr_n=1, io_sel=0, ad_oe=0, busy=0, done=0, err=0, pc_o=RESET_PC and acc_o=0.
- R2: In the first cycle after a start accepted in idle (fetch T1), {a_hi, ad_o} equals pc_o, ad_oe=1, addr_strobe=1 and io_sel=0.
- R3: Fetch T2 and T3 hold rd_n=0 with ad_oe=0. The opcode is the value of ad_i at the end of T3. T4 has rd_n=1, so the fetch lasts four cycles.
- R4: The port-number read puts pc_o+1 (16-bit wrap, with carry into the high byte) on {a_hi, ad_o} at its T1 with addr_strobe=1. It holds rd_n=0 in T2 and T3, and the port number is ad_i at the end of T3.
- R5: In the I/O cycle, T1 drives the port number on both a_hi and ad_o with addr_strobe=1. io_sel=1 for all three T-states of that cycle and in no other cycle.
- R6: For opcode D3h (output), I/O T2 and T3 drive ad_oe=1, ad_o=acc_o and wr_n=0, while rd_n stays 1.
- R7: For opcode DBh (input), I/O T2 and T3 drive rd_n=0 with wr_n=1. acc_o takes the ad_i value from the end of T3.
- R8: addr_strobe is high for single cycles only: cycles 1, 5 and 8 of a full instruction. rd_n and wr_n are never low together.
- R9: One cycle after the last I/O T-state, busy=0 and done is high for exactly one cycle. In that same cycle pc_o has grown by 2 (mod 2^16).
- R10: Any opcode other than D3h and DBh gives err high for one cycle, right after fetch T4. No port-number read or I/O cycle follows, and pc_o and acc_o keep their values.
- R11: start is ignored while an instruction is in progress: each start accepted in idle yields exactly one instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one instruction at pc_o (sampled in idle) |
| ad_i | input | 8 | Read data from the multiplexed bus |
| ad_o | output | 8 | Low address or write data onto the multiplexed bus |
| ad_oe | output | 1 | Drive enable for ad_o |
| a_hi | output | 8 | High address byte |
| addr_strobe | output | 1 | Address latch strobe, T1 only |
| io_sel | output | 1 | High for an I/O cycle, low for memory |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle pulse when an instruction completes |
| err | output | 1 | One-cycle pulse on an unsupported opcode |
| pc_o | output | 16 | Program counter |
| acc_o | output | 8 | Accumulator |

## Verification
Most wrong internal states show up on the strobes within one cycle. A T-state that is skipped or repeated moves the addr_strobe, rd_n or wr_n pattern at once, and the bench compares that pattern cycle by cycle. A wrong capture of the opcode or port number appears at the next T1, either as a wrong port on a_hi/ad_o or as err in place of an I/O cycle. A wrong accumulator capture shows up no later than the next output instruction's write data. A program counter off by one shows in the done-cycle value and in the next fetch address.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int HI_W   = ADDR_W - DATA_W;

  localparam logic [DATA_W-1:0] OPC_PORT_OUT = 8'hD3;
  localparam logic [DATA_W-1:0] OPC_PORT_IN  = 8'hDB;

  // Insn length in bytes; the counter steps by this after completion.
  localparam logic [ADDR_W-1:0] INSN_LEN = 16'd2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_F1, ST_F2, ST_F3, ST_F4,   // opcode fetch
    ST_P1, ST_P2, ST_P3,          // port-number read
    ST_X1, ST_X2, ST_X3           // I/O transfer
  } seq_state_e;

  function automatic logic opcode_known(input logic [DATA_W-1:0] op);
    return (op == OPC_PORT_OUT) || (op == OPC_PORT_IN);
  endfunction

  function automatic logic opcode_is_input(input logic [DATA_W-1:0] op);
    return op == OPC_PORT_IN;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_offset(input logic [ADDR_W-1:0] base,
                                                    input logic [ADDR_W-1:0] step);
    return base + step;
  endfunction
endpackage

// File: rtl/io_seq_fsm.sv
module io_seq_fsm
  import io_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] opcode_i,
  output seq_state_e        state_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  seq_state_e st_q, st_d;
  logic       fin_evt;   // last I/O T-state
  logic       bad_evt;   // fetch ended on an unknown opcode

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_F1;
      ST_F1:   st_d = ST_F2;
      ST_F2:   st_d = ST_F3;
      ST_F3:   st_d = ST_F4;
      ST_F4:   st_d = opcode_known(opcode_i) ? ST_P1 : ST_IDLE;
      ST_P1:   st_d = ST_P2;
      ST_P2:   st_d = ST_P3;
      ST_P3:   st_d = ST_X1;
      ST_X1:   st_d = ST_X2;
      ST_X2:   st_d = ST_X3;
      ST_X3:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign fin_evt = (st_q == ST_X3);
  assign bad_evt = (st_q == ST_F4) && !opcode_known(opcode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= fin_evt;
      err_o  <= bad_evt;
    end
  end

  assign state_o = st_q;
  assign busy_o  = (st_q != ST_IDLE);

  // R9: completion marker is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10: error pulse is single-cycle and never coincides with done
  a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);
  a_r10_err_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_o && done_o));
  // R11: a start seen mid-instruction never restarts the fetch
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && st_q != ST_X3 && st_q != ST_F4) |=> st_q != ST_F1);
endmodule

// File: rtl/io_seq_regs.sv
module io_seq_regs
  import io_seq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = 16'h2050
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic              done_i,
  input  logic              err_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] opcode_o,
  output logic [DATA_W-1:0] port_o,
  output logic [DATA_W-1:0] acc_o
);
  logic cap_op, cap_port, cap_acc, pc_step;

  assign cap_op   = (state_i == ST_F3);
  assign cap_port = (state_i == ST_P3);
  assign cap_acc  = (state_i == ST_X3) && opcode_is_input(opcode_o);
  assign pc_step  = (state_i == ST_X3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o     <= RESET_PC;
      opcode_o <= '0;
      port_o   <= '0;
      acc_o    <= '0;
    end else begin
      if (cap_op)   opcode_o <= ad_i;
      if (cap_port) port_o   <= ad_i;
      if (cap_acc)  acc_o    <= ad_i;
      if (pc_step)  pc_o     <= addr_offset(pc_o, INSN_LEN);
    end
  end

  // R9: counter has moved past both instruction bytes when done shows
  a_r9_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> pc_o == $past(pc_o) + INSN_LEN);
  // R10: unsupported opcode leaves counter and accumulator alone
  a_r10_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    err_i |-> ($stable(pc_o) && $stable(acc_o)));
endmodule

// File: rtl/io_seq_bus.sv
module io_seq_bus
  import io_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] opcode_i,
  input  logic [DATA_W-1:0] port_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [HI_W-1:0]   a_hi_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              strobe_o,
  output logic              io_sel_o,
  output logic              rd_n_o,
  output logic              wr_n_o
);
  logic [ADDR_W-1:0] arg_addr;
  logic              out_dir;

  assign arg_addr = addr_offset(pc_i, 16'd1);
  assign out_dir  = !opcode_is_input(opcode_i);

  always_comb begin
    a_hi_o   = '0;
    ad_o     = '0;
    ad_oe_o  = 1'b0;
    strobe_o = 1'b0;
    io_sel_o = 1'b0;
    rd_n_o   = 1'b1;
    wr_n_o   = 1'b1;
    unique case (state_i)
      ST_F1: begin
        a_hi_o   = pc_i[ADDR_W-1:DATA_W];
        ad_o     = pc_i[DATA_W-1:0];
        ad_oe_o  = 1'b1;
        strobe_o = 1'b1;
      end
      ST_F2, ST_F3: begin
        a_hi_o = pc_i[ADDR_W-1:DATA_W];
        rd_n_o = 1'b0;
      end
      ST_F4: a_hi_o = pc_i[ADDR_W-1:DATA_W];
      ST_P1: begin
        a_hi_o   = arg_addr[ADDR_W-1:DATA_W];
        ad_o     = arg_addr[DATA_W-1:0];
        ad_oe_o  = 1'b1;
        strobe_o = 1'b1;
      end
      ST_P2, ST_P3: begin
        a_hi_o = arg_addr[ADDR_W-1:DATA_W];
        rd_n_o = 1'b0;
      end
      ST_X1: begin
        a_hi_o   = port_i;
        ad_o     = port_i;
        ad_oe_o  = 1'b1;
        strobe_o = 1'b1;
        io_sel_o = 1'b1;
      end
      ST_X2, ST_X3: begin
        a_hi_o   = port_i;
        io_sel_o = 1'b1;
        if (out_dir) begin
          ad_o    = acc_i;
          ad_oe_o = 1'b1;
          wr_n_o  = 1'b0;
        end else begin
          rd_n_o  = 1'b0;
        end
      end
      default: ;
    endcase
  end

  // R8: read and write strobes are mutually exclusive
  a_r8_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));
  // R8: address strobe lasts one cycle
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);
  // R6: a write strobe always has data driven in an I/O cycle
  a_r6_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_o |-> (ad_oe_o && io_sel_o));
  // R5: an I/O cycle begins with the address strobe
  a_r5_io_starts_t1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_sel_o) |-> strobe_o);
endmodule

// File: rtl/io_insn_sequencer.sv
module io_insn_sequencer
  import io_seq_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h2050
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  ad_i,
  output logic [7:0]  ad_o,
  output logic        ad_oe,
  output logic [7:0]  a_hi,
  output logic        addr_strobe,
  output logic        io_sel,
  output logic        rd_n,
  output logic        wr_n,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [15:0] pc_o,
  output logic [7:0]  acc_o
);
  seq_state_e        state;
  logic [DATA_W-1:0] opcode;
  logic [DATA_W-1:0] port;

  io_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .opcode_i (opcode),
    .state_o  (state),
    .busy_o   (busy),
    .done_o   (done),
    .err_o    (err)
  );

  io_seq_regs #(.RESET_PC(RESET_PC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_i  (state),
    .ad_i     (ad_i),
    .done_i   (done),
    .err_i    (err),
    .pc_o     (pc_o),
    .opcode_o (opcode),
    .port_o   (port),
    .acc_o    (acc_o)
  );

  io_seq_bus u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_i  (state),
    .pc_i     (pc_o),
    .opcode_i (opcode),
    .port_i   (port),
    .acc_i    (acc_o),
    .a_hi_o   (a_hi),
    .ad_o     (ad_o),
    .ad_oe_o  (ad_oe),
    .strobe_o (addr_strobe),
    .io_sel_o (io_sel),
    .rd_n_o   (rd_n),
    .wr_n_o   (wr_n)
  );
endmodule

// File: tb/io_insn_sequencer_bench.sv
`timescale 1ns/1ps
module io_insn_sequencer_bench;
  localparam logic [15:0] START_PC = 16'h30FB;

  typedef struct packed {
    logic [1:0]  kind;   // 0 port write, 1 done, 2 error
    logic [15:0] a;
    logic [7:0]  b;
  } scb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  ad_i;
  logic [7:0]  ad_o, a_hi, acc_o;
  logic        ad_oe, addr_strobe, io_sel, rd_n, wr_n, busy, done, err;
  logic [15:0] pc_o;

  logic [7:0]  mem [0:255];
  logic [15:0] addr_l;
  scb_item_t   exp_q [$];
  int          checks = 0;
  int          errors = 0;
  logic [15:0] pc_model = START_PC;
  logic [7:0]  acc_model = 8'h00;
  logic        wr_prev = 1'b1;

  always #4 clk = ~clk;

  io_insn_sequencer #(.RESET_PC(START_PC)) u_io_insn_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .ad_i(ad_i), .ad_o(ad_o),
    .ad_oe(ad_oe), .a_hi(a_hi), .addr_strobe(addr_strobe), .io_sel(io_sel),
    .rd_n(rd_n), .wr_n(wr_n), .busy(busy), .done(done), .err(err),
    .pc_o(pc_o), .acc_o(acc_o)
  );

  function automatic logic [7:0] port_val(input logic [7:0] p);
    return {p[3:0], p[7:4]} ^ 8'hA5;
  endfunction

  // expected {strobe, rd_n, wr_n, io_sel} in cycle k of an instruction
  function automatic logic [3:0] exp_sig(input int k, input bit is_in);
    logic s, r, w, m;
    s = (k == 1) || (k == 5) || (k == 8);
    r = !((k == 2) || (k == 3) || (k == 6) || (k == 7) || (is_in && k >= 9));
    w = !(!is_in && k >= 9);
    m = (k >= 8);
    return {s, r, w, m};
  endfunction

  // external address latch and bus responder
  always_ff @(posedge clk) if (addr_strobe) addr_l <= {a_hi, ad_o};
  always_comb ad_i = rd_n ? 8'hEE : (io_sel ? port_val(addr_l[7:0]) : mem[addr_l[7:0]]);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_sim();
    chk(exp_q.size() == 0, "R9 R10 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: pops scoreboard on write, done and error events
  always @(negedge clk) begin
    if (rst_n) begin
      scb_item_t it;
      if (!wr_n && wr_prev) begin
        if (exp_q.size() == 0) chk(0, "R6 unexpected write", {a_hi, ad_o}, 0);
        else begin
          it = exp_q.pop_front();
          chk(it.kind == 2'd0, "R6 write kind", it.kind, 0);
          chk(a_hi == it.a[7:0], "R5 write port", a_hi, it.a[7:0]);
          chk(ad_oe && ad_o == it.b, "R6 write data", ad_o, it.b);
        end
      end
      if (done) begin
        if (exp_q.size() == 0) chk(0, "R11 unexpected done", pc_o, 0);
        else begin
          it = exp_q.pop_front();
          chk(it.kind == 2'd1, "R9 done kind", it.kind, 1);
          chk(pc_o == it.a, "R9 pc step", pc_o, it.a);
          chk(acc_o == it.b, "R7 accumulator", acc_o, it.b);
        end
      end
      if (err) begin
        if (exp_q.size() == 0) chk(0, "R10 unexpected err", pc_o, 0);
        else begin
          it = exp_q.pop_front();
          chk(it.kind == 2'd2, "R10 err kind", it.kind, 2);
          chk(pc_o == it.a && acc_o == it.b, "R10 regs held", {pc_o, acc_o}, {it.a, it.b});
        end
      end
      wr_prev = wr_n;
    end
  end

  // driver: loads program bytes, queues expectations, checks bus timing
  task automatic run_insn(input logic [7:0] op, input logic [7:0] port, input bit hold);
    bit known = (op == 8'hD3) || (op == 8'hDB);
    bit is_in = (op == 8'hDB);
    int n = known ? 10 : 4;
    logic [15:0] pc0 = pc_model;
    logic [15:0] pc1 = pc_model + 16'd1;
    logic [3:0] sig;
    mem[pc0[7:0]] = op;
    mem[pc1[7:0]] = port;
    if (!known) exp_q.push_back('{2'd2, pc_model, acc_model});
    else begin
      if (is_in) acc_model = port_val(port);
      else exp_q.push_back('{2'd0, {8'h00, port}, acc_model});
      pc_model = pc_model + 16'd2;
      exp_q.push_back('{2'd1, pc_model, acc_model});
    end
    @(negedge clk);
    start = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (!hold || k == n) start = 1'b0;
      sig = {addr_strobe, rd_n, wr_n, io_sel};
      chk(sig == exp_sig(k, is_in), "R3 R4 R5 R6 R7 R8 cycle pattern", {k[7:0], 4'h0, sig},
          {k[7:0], 4'h0, exp_sig(k, is_in)});
      if (k == 1) chk({a_hi, ad_o} == pc0 && ad_oe, "R2 fetch address", {a_hi, ad_o}, pc0);
      if (k == 2) chk(!ad_oe, "R3 bus released", ad_oe, 0);
      if (k == 5) chk({a_hi, ad_o} == pc1 && ad_oe, "R4 port read address", {a_hi, ad_o}, pc1);
      if (k == 8) chk(a_hi == port && ad_o == port, "R5 port on both bytes", {a_hi, ad_o}, {port, port});
      if (k == 9 && !is_in) chk(ad_o == acc_model, "R6 acc on bus", ad_o, acc_model);
    end
    @(negedge clk);
    chk(!busy && !addr_strobe && !io_sel, "R10 R11 idle after insn", {busy, addr_strobe, io_sel}, 0);
    chk(done == known && err == !known, "R9 R10 end pulse", {done, err}, {known, !known});
    @(negedge clk);
    chk(!busy && !done && !err && !addr_strobe, "R11 no restart", {busy, done, err, addr_strobe}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_sim();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk({addr_strobe, rd_n, wr_n, io_sel, ad_oe} == 5'b01100, "R1 idle bus",
        {addr_strobe, rd_n, wr_n, io_sel, ad_oe}, 5'b01100);
    chk(!busy && !done && !err, "R1 status low", {busy, done, err}, 0);
    chk(pc_o == START_PC && acc_o == 8'h00, "R1 registers", {pc_o, acc_o}, {START_PC, 8'h00});
    run_insn(8'hDB, 8'h84, 1'b0);  // R7 input
    run_insn(8'hD3, 8'h01, 1'b0);  // R6 output
    run_insn(8'h00, 8'h00, 1'b0);  // R10 unknown opcode
    run_insn(8'hDB, 8'hFF, 1'b0);  // R4 carry into high byte on port read
    run_insn(8'hD3, 8'hF8, 1'b1);  // R11 start held high throughout
    run_insn(8'hD2, 8'h11, 1'b1);  // R10 near-miss opcode, start held
    run_insn(8'hDB, 8'hFA, 1'b0);
    run_insn(8'hD3, 8'h02, 1'b0);
    repeat (3) @(negedge clk);
    finish_sim();
  end
endmodule